// File: doc/BRIEF.md
# Channel Standby and Fault Supervisor

This block decides, for the transmit half and the receive half of a voice codec, whether each half is running or idle, and whether its digital outputs may touch the shared PCM bus. It runs on a free-running reference clock. The power-down pin, both frame syncs, both master clocks and the rate select all enter through a synchroniser. From the frame syncs and master clocks it keeps a per-channel activity state, a power-up hold and a clock-loss alarm.

A frame period is measured in master-clock cycles, and the number of cycles depends on the rate select. Both the sync-absence timeout and the power-up hold are counted in frame periods, so they scale with the selected rate. Clock loss is timed on the reference clock. A channel that has stopped clocking is therefore caught even though it no longer produces frame periods. The outputs are one enable that gates both the transmit data and the timeslot strobe drivers, and one force-low request for the receive signalling output.

Top module: `chan_standby_sup`

## Requirements
- R1: While the synchronised power-down input `pdn_n` is low, both `tx_active` and `rx_active` are 0 from the next cycle on, `tx_oe` is 0 and `rx_sig_low` is 1.
- R2: After reset both channels are in standby. A channel becomes active when a rising edge of its frame sync is seen while `pdn_n` is high.
- R3: An active channel drops to standby once its frame sync has stayed low through `STBY_FRAMES` consecutive frame periods of its own master clock. The other channel is not affected.
- R4: `tx_oe` is 1 only while the transmit channel is active. `rx_sig_low` is 1 whenever the receive channel is in standby.
- R5: After reset, `tx_oe` stays 0 and `rx_sig_low` stays 1 until `PWRUP_FRAMES` frame periods of that channel's master clock have passed, even if the channel is already active.
- R6: A frame period is 192, 193 or 256 rising edges of the master clock for `clk_sel` = 2'b00, 2'b01 and 2'b10 respectively.
- R7: `clk_sel` = 2'b11 is not a legal rate. While it is applied, `tx_oe` is 0 and `rx_sig_low` is 1. Normal output control returns when a legal code is restored.
- R8: If a channel's master clock shows no rising edge for `LOSS_CYCLES` reference cycles, that channel's outputs go safe (`tx_oe` 0, or `rx_sig_low` 1). The channel's active state is kept, and the outputs recover on the next master-clock edge.
- R9: When `pdn_n` returns high, both channels stay in standby until their own frame sync pulses again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| pdn_n | input | 1 | Power-down pin; high = device enabled |
| fs_tx | input | 1 | Transmit frame sync |
| fs_rx | input | 1 | Receive frame sync |
| mclk_tx | input | 1 | Transmit master clock, sampled on clk_ref |
| mclk_rx | input | 1 | Receive master clock, sampled on clk_ref |
| clk_sel | input | 2 | Master clock rate select (00, 01, 10 legal) |
| tx_active | output | 1 | Transmit channel is active |
| rx_active | output | 1 | Receive channel is active |
| tx_oe | output | 1 | Drive enable for transmit data and timeslot strobe |
| rx_sig_low | output | 1 | Force the receive signalling output low |

## Verification
The bench builds the block with `STBY_FRAMES` = 4, `PWRUP_FRAMES` = 2 and `LOSS_CYCLES` = 16. The master clocks run at a quarter of the reference rate. With these values a frame lasts 768 to 1024 reference cycles, so sync-absence standby, the end of the power-up hold and clock-loss recovery all fall within a few thousand cycles. The gap between the 192-edge and 256-edge frame lengths is also wider than the uncertainty in the absence-timeout phase. This lets the bench tell the rate codes apart purely by when standby begins.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic {
    CH_STANDBY = 1'b0,
    CH_ACTIVE  = 1'b1
  } ch_state_e;

  localparam int FRAME_W = 9;

  // Master-clock edges per frame for each rate code; zero marks an illegal code.
  function automatic logic [FRAME_W-1:0] frame_edges(input logic [1:0] sel);
    logic [FRAME_W-1:0] n;
    case (sel)
      2'b00:   n = 9'd192;
      2'b01:   n = 9'd193;
      2'b10:   n = 9'd256;
      default: n = 9'd0;
    endcase
    return n;
  endfunction

  function automatic logic rate_legal(input logic [1:0] sel);
    return sel != 2'b11;
  endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sup_clk_watch.sv
module sup_clk_watch
  import sup_pkg::*;
#(
  parameter int LOSS_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mclk_s,
  input  logic [1:0] sel,
  output logic       mclk_edge,
  output logic       frame_tick,
  output logic       clk_lost
);
  localparam int LW = $clog2(LOSS_CYCLES + 1);

  logic               mclk_q;
  logic [FRAME_W-1:0] edge_cnt;
  logic [FRAME_W-1:0] last_edge;
  logic [LW-1:0]      idle_cnt;
  logic               sel_ok;

  assign sel_ok     = rate_legal(sel);
  assign last_edge  = frame_edges(sel) - 9'd1;
  assign mclk_edge  = mclk_s & ~mclk_q;
  assign frame_tick = sel_ok & mclk_edge & (edge_cnt >= last_edge);
  assign clk_lost   = (idle_cnt == LW'(LOSS_CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mclk_q   <= 1'b0;
      edge_cnt <= '0;
      idle_cnt <= '0;
    end else begin
      mclk_q <= mclk_s;
      if (!sel_ok)           edge_cnt <= '0;
      else if (frame_tick)   edge_cnt <= '0;
      else if (mclk_edge)    edge_cnt <= edge_cnt + 9'd1;
      if (mclk_edge)         idle_cnt <= '0;
      else if (!clk_lost)    idle_cnt <= idle_cnt + LW'(1);
    end
  end
endmodule

// File: rtl/sup_chan.sv
module sup_chan
  import sup_pkg::*;
#(
  parameter int STBY_FRAMES  = 240,
  parameter int PWRUP_FRAMES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pdn,
  input  logic fs,
  input  logic frame_tick,
  output logic active,
  output logic pwr_hold,
  output logic fs_rise,
  output logic sync_gone
);
  localparam int AW = $clog2(STBY_FRAMES + 1);
  localparam int PW = $clog2(PWRUP_FRAMES + 1);

  ch_state_e     state;
  logic          fs_q;
  logic [AW-1:0] absent_cnt;
  logic [PW-1:0] pup_cnt;

  assign fs_rise   = fs & ~fs_q;
  assign sync_gone = (absent_cnt == AW'(STBY_FRAMES));
  assign pwr_hold  = (pup_cnt != PW'(PWRUP_FRAMES));
  assign active    = (state == CH_ACTIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= CH_STANDBY;
      fs_q       <= 1'b0;
      absent_cnt <= '0;
      pup_cnt    <= '0;
    end else begin
      fs_q <= fs;
      if (fs)                            absent_cnt <= '0;
      else if (frame_tick && !sync_gone) absent_cnt <= absent_cnt + AW'(1);
      if (frame_tick && pwr_hold)        pup_cnt <= pup_cnt + PW'(1);
      if (!pdn)                          state <= CH_STANDBY;
      else if (fs_rise)                  state <= CH_ACTIVE;
      else if (sync_gone)                state <= CH_STANDBY;
    end
  end
endmodule

// File: rtl/chan_standby_sup.sv
module chan_standby_sup
  import sup_pkg::*;
#(
  parameter int STBY_FRAMES  = 240,
  parameter int PWRUP_FRAMES = 4,
  parameter int LOSS_CYCLES  = 1000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       pdn_n,
  input  logic       fs_tx,
  input  logic       fs_rx,
  input  logic       mclk_tx,
  input  logic       mclk_rx,
  input  logic [1:0] clk_sel,
  output logic       tx_active,
  output logic       rx_active,
  output logic       tx_oe,
  output logic       rx_sig_low
);
  localparam int NCH  = 2;
  localparam int IN_W = 3 + 2 * NCH;

  logic [IN_W-1:0] raw_in, sync_in;
  logic            pdn_s, sel_ok;
  logic [1:0]      sel_s;
  logic [NCH-1:0]  fs_s, mclk_s;
  logic [NCH-1:0]  mclk_edge, frame_tick, clk_lost;
  logic [NCH-1:0]  ch_active, pwr_hold, fs_rise, sync_gone, out_ok;

  assign raw_in = {clk_sel, mclk_rx, mclk_tx, fs_rx, fs_tx, pdn_n};

  sup_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_ref), .rst_n(rst_n), .d(raw_in), .q(sync_in)
  );

  assign pdn_s  = sync_in[0];
  assign fs_s   = sync_in[2:1];
  assign mclk_s = sync_in[4:3];
  assign sel_s  = sync_in[6:5];
  assign sel_ok = rate_legal(sel_s);

  // index 0 = transmit, index 1 = receive
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    sup_clk_watch #(.LOSS_CYCLES(LOSS_CYCLES)) u_watch (
      .clk(clk_ref), .rst_n(rst_n), .mclk_s(mclk_s[ch]), .sel(sel_s),
      .mclk_edge(mclk_edge[ch]), .frame_tick(frame_tick[ch]), .clk_lost(clk_lost[ch])
    );
    sup_chan #(.STBY_FRAMES(STBY_FRAMES), .PWRUP_FRAMES(PWRUP_FRAMES)) u_chan (
      .clk(clk_ref), .rst_n(rst_n), .pdn(pdn_s), .fs(fs_s[ch]),
      .frame_tick(frame_tick[ch]), .active(ch_active[ch]), .pwr_hold(pwr_hold[ch]),
      .fs_rise(fs_rise[ch]), .sync_gone(sync_gone[ch])
    );
    assign out_ok[ch] = ch_active[ch] & ~pwr_hold[ch] & ~clk_lost[ch] & pdn_s & sel_ok;
  end

  assign tx_active  = ch_active[0];
  assign rx_active  = ch_active[1];
  assign tx_oe      = out_ok[0];
  assign rx_sig_low = ~out_ok[1];
endmodule

// File: rtl/sup_checker.sv
module sup_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pdn_s,
  input logic       sel_ok,
  input logic [1:0] fs_rise,
  input logic [1:0] mclk_edge,
  input logic [1:0] clk_lost,
  input logic [1:0] pwr_hold,
  input logic [1:0] sync_gone,
  input logic       tx_active,
  input logic       rx_active,
  input logic       tx_oe,
  input logic       rx_sig_low
);
  assert_pdn_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pdn_s |=> (!tx_active && !rx_active));

  assert_tx_wake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_active) |-> $past(fs_rise[0]));

  assert_rx_wake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_active) |-> $past(fs_rise[1]));

  assert_tx_sleep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_active) |-> ($past(sync_gone[0]) || !$past(pdn_s)));

  assert_tx_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> !tx_oe);

  assert_rx_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_active |-> rx_sig_low);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_hold[0] |-> !tx_oe) and (pwr_hold[1] |-> rx_sig_low));

  assert_bad_rate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ok |-> (!tx_oe && rx_sig_low));

  assert_loss_safe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_lost[0] |-> !tx_oe) and (clk_lost[1] |-> rx_sig_low));

  assert_edge_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_edge[0] |=> !clk_lost[0]);
endmodule

bind chan_standby_sup sup_checker u_chk (
  .clk(clk_ref), .rst_n(rst_n), .pdn_s(pdn_s), .sel_ok(sel_ok),
  .fs_rise(fs_rise), .mclk_edge(mclk_edge), .clk_lost(clk_lost),
  .pwr_hold(pwr_hold), .sync_gone(sync_gone), .tx_active(tx_active),
  .rx_active(rx_active), .tx_oe(tx_oe), .rx_sig_low(rx_sig_low)
);

// File: tb/sim_chan_standby_sup.sv
`timescale 1ns/1ps
module sim_chan_standby_sup;
  logic clk_ref = 1'b0;
  logic rst_n = 1'b0;
  logic pdn_n = 1'b1;
  logic fs_tx = 1'b0, fs_rx = 1'b0;
  logic mclk_tx = 1'b0, mclk_rx = 1'b0;
  logic mtx_run = 1'b1, mrx_run = 1'b1;
  logic [1:0] clk_sel = 2'b00;
  logic tx_active, rx_active, tx_oe, rx_sig_low;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk_ref = ~clk_ref;
  always #10 if (mtx_run) mclk_tx = ~mclk_tx;
  always #10 if (mrx_run) mclk_rx = ~mclk_rx;

  chan_standby_sup #(.STBY_FRAMES(4), .PWRUP_FRAMES(2), .LOSS_CYCLES(16)) u0 (
    .clk_ref(clk_ref), .rst_n(rst_n), .pdn_n(pdn_n), .fs_tx(fs_tx), .fs_rx(fs_rx),
    .mclk_tx(mclk_tx), .mclk_rx(mclk_rx), .clk_sel(clk_sel),
    .tx_active(tx_active), .rx_active(rx_active), .tx_oe(tx_oe), .rx_sig_low(rx_sig_low)
  );

  // reference cycles per frame: master clock period is 4 reference cycles
  function automatic int frame_ref_cycles(input logic [1:0] s);
    if (s == 2'b10) return 256 * 4;
    if (s == 2'b01) return 193 * 4;
    return 192 * 4;
  endfunction

  typedef struct packed {
    logic        pdn;
    logic        ftx;
    logic        frx;
    logic        mtx;
    logic        mrx;
    logic [1:0]  sel;
    logic [15:0] cycles;
    logic [3:0]  expect_v; // {tx_active, rx_active, tx_oe, rx_sig_low}
    logic [3:0]  req;
  } row_t;

  localparam int NROWS = 16;
  localparam row_t ROWS [NROWS] = '{
    '{1'b1,1'b1,1'b1,1'b1,1'b1,2'b00,16'd800, 4'b1110,4'd2}, // R2 steady active
    '{1'b1,1'b0,1'b1,1'b1,1'b1,2'b00,16'd3300,4'b0100,4'd3}, // R3 tx alone to standby
    '{1'b1,1'b1,1'b1,1'b1,1'b1,2'b00,16'd800, 4'b1110,4'd2}, // R2 tx wakes
    '{1'b1,1'b1,1'b0,1'b1,1'b1,2'b00,16'd3300,4'b1011,4'd4}, // R4 rx standby forces low
    '{1'b0,1'b1,1'b1,1'b1,1'b1,2'b00,16'd100, 4'b0001,4'd1}, // R1 power-down
    '{1'b1,1'b0,1'b0,1'b1,1'b1,2'b00,16'd100, 4'b0001,4'd9}, // R9 no sync, stay down
    '{1'b1,1'b1,1'b1,1'b1,1'b1,2'b00,16'd800, 4'b1110,4'd9}, // R9 sync pulses wake
    '{1'b1,1'b1,1'b1,1'b0,1'b1,2'b00,16'd100, 4'b1100,4'd8}, // R8 tx clock lost
    '{1'b1,1'b1,1'b1,1'b1,1'b1,2'b00,16'd100, 4'b1110,4'd8}, // R8 tx clock back
    '{1'b1,1'b1,1'b1,1'b1,1'b0,2'b00,16'd100, 4'b1111,4'd8}, // R8 rx clock lost
    '{1'b1,1'b1,1'b1,1'b1,1'b1,2'b11,16'd100, 4'b1101,4'd7}, // R7 illegal rate code
    '{1'b1,1'b1,1'b1,1'b1,1'b1,2'b00,16'd100, 4'b1110,4'd7}, // R7 legal code restored
    '{1'b1,1'b1,1'b1,1'b1,1'b1,2'b10,16'd1040,4'b1110,4'd6}, // R6 256-edge frames
    '{1'b1,1'b0,1'b1,1'b1,1'b1,2'b10,16'd2900,4'b1110,4'd6}, // R6 not yet 4 long frames
    '{1'b1,1'b0,1'b1,1'b1,1'b1,2'b10,16'd1300,4'b0100,4'd6}, // R6 R3 standby after 4 frames
    '{1'b1,1'b1,1'b1,1'b1,1'b1,2'b01,16'd800, 4'b1110,4'd2}  // R2 wake at 193-edge rate
  };

  task automatic check(input logic [3:0] exp_v, input int req, input string what);
    logic [3:0] got;
    got = {tx_active, rx_active, tx_oe, rx_sig_low};
    checks++;
    if (got !== exp_v) begin
      errors++;
      $display("FAIL R%0d %s: got %b expected %b (tx_active rx_active tx_oe rx_sig_low)",
               req, what, got, exp_v);
    end
  endtask

  task automatic run(input int n, input logic ftx, input logic frx);
    int per;
    per = frame_ref_cycles(clk_sel);
    for (int c = 0; c < n; c++) begin
      @(negedge clk_ref);
      fs_tx = ftx && ((c % per) < 8);
      fs_rx = frx && ((c % per) < 8);
    end
  endtask

  initial begin
    // reset state: R2 standby, outputs safe
    repeat (10) @(negedge clk_ref);
    check(4'b0001, 2, "reset state");
    rst_n = 1'b1;
    run(200, 1'b1, 1'b1);
    check(4'b1101, 5, "active but power-up hold"); // R5
    run(1800, 1'b1, 1'b1);
    check(4'b1110, 5, "power-up hold released"); // R5
    for (int i = 0; i < NROWS; i++) begin
      pdn_n   = ROWS[i].pdn;
      clk_sel = ROWS[i].sel;
      mtx_run = ROWS[i].mtx;
      mrx_run = ROWS[i].mrx;
      run(int'(ROWS[i].cycles), ROWS[i].ftx, ROWS[i].frx);
      check(ROWS[i].expect_v, int'(ROWS[i].req), $sformatf("table row %0d", i));
    end
    // corner: reset again with transmit clock stopped; hold never ends, R5 and R8
    rst_n = 1'b0;
    mtx_run = 1'b0;
    clk_sel = 2'b00;
    repeat (5) @(negedge clk_ref);
    check(4'b0001, 1, "second reset"); // R1 style safe state during reset
    rst_n = 1'b1;
    run(1800, 1'b1, 1'b1);
    check(4'b1100, 5, "no tx frames, tx still held"); // R5 R8
    mtx_run = 1'b1;
    run(1800, 1'b1, 1'b1);
    check(4'b1110, 5, "tx clock resumed, hold expires"); // R5
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_ref);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule